// File: doc/BRIEF.md
# Refresh-Aware Initial Latency Sequencer

This block sits on the device side of a serial memory port. It times one chip-select transaction from the first command/address clock to the first data word. On the first rising edge at which chip select is seen low, it captures the transaction type, the latency configuration and the state of the internal refresh engine. From these it works out when the data phase may begin. A refresh that collides with the access doubles the wait in variable mode. Fixed mode always applies the doubled wait, so the host sees the same timing every time.

While the command/address clocks are in progress, the block drives the shared strobe line to advertise whether a refresh collision was seen. After that phase it releases the strobe on write transactions. On read transactions it keeps the strobe driven low, can add one dummy strobe cycle, and then hands the strobe over to the read data path. A single-cycle pulse marks the first data cycle. A latency code outside the supported range raises a fault flag and the transaction never starts. Raising chip select ends the transaction at any point.

Top module: `refresh_latency_ctrl`

## Requirements
- R1: Cycle 0 of a transaction is the clock period after the first rising edge at which `cs_n` is sampled low while idle. The type, configuration and `refresh_busy` are sampled at that edge only, and later changes to `refresh_busy` have no effect on that transaction. Type encoding on `txn_kind`: 00 memory read, 01 memory write, 10 register read, 11 register write.
- R2: Latency codes 0 to 5 give a base count L of code + 3 clocks.
- R3: In variable mode (`fixed_mode`=0), a memory read or write asserts `data_go` in cycle 2+L when no refresh was sampled, and in cycle 2+2L when one was.
- R4: In fixed mode, memory reads, memory writes and register reads always assert `data_go` in cycle 2+2L.
- R5: A register write asserts `data_go` in cycle 3, directly after the three command/address cycles. This holds for every mode and refresh state.
- R6: In variable mode, a register read asserts `data_go` in cycle 2+L without a refresh collision and in cycle 2+2L with one.
- R7: In cycles 0 to 2, `strb_oe` is 1 and `strb_val` equals the sampled `refresh_busy`.
- R8: Writes (types 01 and 11) hold `strb_oe` at 0 from cycle 3 onward.
- R9: Reads (types 00 and 10) keep `strb_oe`=1 from cycle 3 up to the cycle before `data_go`, and release it from the `data_go` cycle. `strb_val` is 0 in that span, except in the last cycle before `data_go`, where it is 1 when `dummy_strobe_en` was sampled as 1.
- R10: `data_go` is a one-cycle pulse. After it, all four outputs stay 0 until `cs_n` rises. Whenever `strb_oe` is 0, `strb_val` is 0.
- R11: Latency codes 6 to 15 set `code_fault` to 1 from cycle 0 until `cs_n` rises. No strobe is driven and no `data_go` is produced.
- R12: If `cs_n` is sampled high at any rising edge, all outputs are 0 in the following cycle, and any pending `data_go` is cancelled.
- R13: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, one tick per command/latency cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing the transaction |
| txn_kind | input | 2 | Decoded transaction type (encoding in R1) |
| lat_code | input | CODE_W (4) | Configured latency code |
| fixed_mode | input | 1 | 1 selects the always-doubled latency |
| dummy_strobe_en | input | 1 | 1 adds one dummy strobe cycle ahead of read data |
| refresh_busy | input | 1 | Internal refresh engine is busy |
| strb_oe | output | 1 | Strobe output enable |
| strb_val | output | 1 | Strobe value while enabled |
| data_go | output | 1 | Pulse in the first data cycle |
| code_fault | output | 1 | Reserved latency code seen for this transaction |

## Verification
The bench builds the block with its defaults: three command/address cycles, counting from cycle 2, base count 3 and six legal codes out of a 4-bit field. The longest wait is then 18 cycles. That makes it cheap to sweep every code, both modes, both refresh states, every transaction type and both dummy-strobe settings, and to compare every output in every cycle of each transaction against an arithmetic model. The refresh input is inverted straight after the capture edge to show it is held. Aborts are placed in the command phase, just before the data pulse, and on a zero-latency register write.

// File: rtl/lat_seq_pkg.sv
package lat_seq_pkg;

   typedef enum logic [1:0] {
      TX_MEM_RD = 2'b00,
      TX_MEM_WR = 2'b01,
      TX_REG_RD = 2'b10,
      TX_REG_WR = 2'b11
   } txn_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_WAIT,
      SQ_DATA,
      SQ_FAULT
   } seq_e;

   function automatic logic txn_is_read(input txn_e t);
      return (t == TX_MEM_RD) || (t == TX_REG_RD);
   endfunction

endpackage

// File: rtl/lat_calc.sv
module lat_calc
   import lat_seq_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter int LAT_BASE  = 3,
   parameter int LAT_CODES = 6,
   parameter int LAT_START = 2,
   parameter int CA_CYCLES = 3,
   parameter int CNT_W     = 5
) (
   input  logic [CODE_W-1:0] code,
   input  logic              fixed,
   input  logic              busy,
   input  logic [1:0]        kind,
   output logic [CNT_W-1:0]  target,
   output logic              reserved,
   output logic              is_rd
);

   localparam logic [CODE_W:0]  CODE_LIM = (CODE_W+1)'(LAT_CODES);
   localparam logic [CNT_W-1:0] BASE_OFS = CNT_W'(LAT_BASE);
   localparam logic [CNT_W-1:0] START_AT = CNT_W'(LAT_START);
   localparam logic [CNT_W-1:0] CA_END   = CNT_W'(CA_CYCLES);

   txn_e             t;
   logic [CNT_W-1:0] base;
   logic             dbl;

   always_comb begin
      t        = txn_e'(kind);
      reserved = {1'b0, code} >= CODE_LIM;
      is_rd    = txn_is_read(t);
      base     = CNT_W'(code) + BASE_OFS;
      dbl      = (t != TX_REG_WR) && (fixed || busy);
      if (t == TX_REG_WR) begin
         target = CA_END;
      end else if (dbl) begin
         target = START_AT + (base << 1);
      end else begin
         target = START_AT + base;
      end
   end

endmodule

// File: rtl/lat_seq.sv
module lat_seq
   import lat_seq_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int CA_CYCLES  = 3,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             bad_code,
   input  logic [CNT_W-1:0] tgt_in,
   input  logic             rd_in,
   input  logic             coll_in,
   input  logic             pre_in,
   output logic             waiting,
   output logic             fault,
   output logic             ph_ca,
   output logic             ph_before,
   output logic             ph_pre,
   output logic             ph_hit,
   output logic             rd_q,
   output logic             coll_q,
   output logic             pre_q
);

   seq_e state_q;
   logic start_ev;

   assign start_ev = (state_q == SQ_IDLE) && !cs_n && !bad_code;
   assign waiting  = (state_q == SQ_WAIT);
   assign fault    = (state_q == SQ_FAULT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         rd_q    <= 1'b0;
         coll_q  <= 1'b0;
         pre_q   <= 1'b0;
      end else if (cs_n) begin
         state_q <= SQ_IDLE;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (bad_code) begin
                  state_q <= SQ_FAULT;
               end else begin
                  state_q <= SQ_WAIT;
                  rd_q    <= rd_in;
                  coll_q  <= coll_in;
                  pre_q   <= pre_in;
               end
            end
            SQ_WAIT:  if (ph_hit) state_q <= SQ_DATA;
            SQ_DATA:  state_q <= SQ_DATA;
            SQ_FAULT: state_q <= SQ_FAULT;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

   generate
      if (COUNT_DOWN) begin : g_down
         localparam int CA_W = $clog2(CA_CYCLES + 1);
         localparam logic [CA_W-1:0] CA_LIM = CA_W'(CA_CYCLES);
         logic [CNT_W-1:0] rem_q;
         logic [CA_W-1:0]  ca_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rem_q <= '0;
               ca_q  <= '0;
            end else if (start_ev) begin
               rem_q <= tgt_in;
               ca_q  <= '0;
            end else if (waiting) begin
               rem_q <= rem_q - 1'b1;
               if (ca_q != CA_LIM) ca_q <= ca_q + 1'b1;
            end
         end
         assign ph_ca     = ca_q < CA_LIM;
         assign ph_before = rem_q != '0;
         assign ph_pre    = rem_q == CNT_W'(1);
         assign ph_hit    = rem_q == '0;
      end else begin : g_up
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] tgt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               tgt_q <= '0;
            end else if (start_ev) begin
               cnt_q <= '0;
               tgt_q <= tgt_in;
            end else if (waiting) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign ph_ca     = cnt_q < CNT_W'(CA_CYCLES);
         assign ph_before = cnt_q < tgt_q;
         assign ph_pre    = (cnt_q + 1'b1) == tgt_q;
         assign ph_hit    = cnt_q == tgt_q;
      end
   endgenerate

   // R1
   start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (waiting && ph_ca));

endmodule

// File: rtl/lat_strobe.sv
module lat_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic fault,
   input  logic ph_ca,
   input  logic ph_before,
   input  logic ph_pre,
   input  logic ph_hit,
   input  logic rd_q,
   input  logic coll_q,
   input  logic pre_q,
   output logic oe,
   output logic val,
   output logic go,
   output logic err
);

   always_comb begin
      go  = waiting && ph_hit;
      err = fault;
      oe  = waiting && (ph_ca || (rd_q && ph_before));
      if (!waiting)   val = 1'b0;
      else if (ph_ca) val = coll_q;
      else            val = rd_q && pre_q && ph_pre;
   end

   // R7
   coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && ph_ca && $past(waiting && ph_ca)) |-> $stable(val));

   // R10
   go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go);

endmodule

// File: rtl/refresh_latency_ctrl.sv
module refresh_latency_ctrl
   import lat_seq_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int LAT_BASE   = 3,
   parameter int LAT_CODES  = 6,
   parameter int LAT_START  = 2,
   parameter int CA_CYCLES  = 3,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [1:0]        txn_kind,
   input  logic [CODE_W-1:0] lat_code,
   input  logic              fixed_mode,
   input  logic              dummy_strobe_en,
   input  logic              refresh_busy,
   output logic              strb_oe,
   output logic              strb_val,
   output logic              data_go,
   output logic              code_fault
);

   localparam int T_MAX = LAT_START + 2 * (LAT_BASE + LAT_CODES - 1);
   localparam int CNT_W = $clog2(T_MAX + 2);

   initial begin
      assert (CA_CYCLES > LAT_START)
         else $fatal(1, "latency must start inside the address phase");
      assert (LAT_START + LAT_BASE >= CA_CYCLES + 1)
         else $fatal(1, "shortest wait must end after the address phase");
      assert (LAT_CODES >= 1 && LAT_CODES <= (1 << CODE_W))
         else $fatal(1, "legal code count does not fit the code field");
   end

   logic [CNT_W-1:0] tgt;
   logic bad_code, rd_live;
   logic waiting, fault, ph_ca, ph_before, ph_pre, ph_hit;
   logic rd_q, coll_q, pre_q;

   lat_calc #(
      .CODE_W(CODE_W), .LAT_BASE(LAT_BASE), .LAT_CODES(LAT_CODES),
      .LAT_START(LAT_START), .CA_CYCLES(CA_CYCLES), .CNT_W(CNT_W)
   ) calc_i (
      .code(lat_code), .fixed(fixed_mode), .busy(refresh_busy),
      .kind(txn_kind), .target(tgt), .reserved(bad_code), .is_rd(rd_live)
   );

   lat_seq #(
      .CNT_W(CNT_W), .CA_CYCLES(CA_CYCLES), .COUNT_DOWN(COUNT_DOWN)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bad_code(bad_code),
      .tgt_in(tgt), .rd_in(rd_live), .coll_in(refresh_busy),
      .pre_in(dummy_strobe_en), .waiting(waiting), .fault(fault),
      .ph_ca(ph_ca), .ph_before(ph_before), .ph_pre(ph_pre),
      .ph_hit(ph_hit), .rd_q(rd_q), .coll_q(coll_q), .pre_q(pre_q)
   );

   lat_strobe strb_i (
      .clk(clk), .rst_n(rst_n), .waiting(waiting), .fault(fault),
      .ph_ca(ph_ca), .ph_before(ph_before), .ph_pre(ph_pre),
      .ph_hit(ph_hit), .rd_q(rd_q), .coll_q(coll_q), .pre_q(pre_q),
      .oe(strb_oe), .val(strb_val), .go(data_go), .err(code_fault)
   );

   // R12
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!strb_oe && !strb_val && !data_go && !code_fault));

   // R11
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_fault |-> (!strb_oe && !data_go));

   // R10
   idle_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_oe |-> !strb_val);

endmodule

// File: tb/refresh_latency_ctrl_tb.sv
module refresh_latency_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic [1:0] txn_kind = 2'b00;
   logic [3:0] lat_code = 4'd0;
   logic       fixed_mode = 1'b0;
   logic       dummy_strobe_en = 1'b0;
   logic       refresh_busy = 1'b0;
   logic       strb_oe, strb_val, data_go, code_fault;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_latency_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .txn_kind(txn_kind),
      .lat_code(lat_code), .fixed_mode(fixed_mode),
      .dummy_strobe_en(dummy_strobe_en), .refresh_busy(refresh_busy),
      .strb_oe(strb_oe), .strb_val(strb_val), .data_go(data_go),
      .code_fault(code_fault)
   );

   task automatic check(input string tag, input logic [3:0] exp);
      logic [3:0] got;
      got = {strb_oe, strb_val, data_go, code_fault};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: {oe,val,go,fault} actual=%b expected=%b (kind=%0d code=%0d fixed=%0b busy=%0b pre=%0b)",
                  tag, got, exp, txn_kind, lat_code, fixed_mode, refresh_busy, dummy_strobe_en);
      end
   endtask

   // abort_k < 0 means the transaction runs to completion
   task automatic run_txn(input logic [1:0] kind, input logic [3:0] code,
                          input logic fx, input logic bs, input logic pr,
                          input int abort_k);
      bit rsv, rd, dbl;
      int base, tgt, last;
      logic [3:0] exp;
      string tag;
      rsv  = code >= 4'd6;
      base = int'(code) + 3;
      rd   = (kind == 2'b00) || (kind == 2'b10);
      dbl  = (kind != 2'b11) && (fx || bs);
      tgt  = (kind == 2'b11) ? 3 : (2 + (dbl ? 2 * base : base));
      last = rsv ? 4 : tgt + 2;
      @(negedge clk);
      txn_kind = kind; lat_code = code; fixed_mode = fx;
      refresh_busy = bs; dummy_strobe_en = pr; cs_n = 1'b0;
      for (int k = 0; k <= last; k++) begin
         @(negedge clk);
         if (k == 0) refresh_busy = !bs;   // R1: must be ignored from here on
         if (rsv) begin
            exp = 4'b0001; tag = "R11";
         end else if (k < 3) begin
            exp = {1'b1, bs, 2'b00}; tag = (k == 0) ? "R7" : "R1/R7";
         end else if (k < tgt) begin
            exp = rd ? {1'b1, (pr && (k == tgt - 1)), 2'b00} : 4'b0000;
            tag = rd ? "R9" : "R8";
         end else if (k == tgt) begin
            exp = 4'b0010;
            if (kind == 2'b11)      tag = "R5";
            else if (fx)            tag = "R2/R4";
            else if (kind == 2'b10) tag = "R2/R6";
            else                    tag = "R2/R3";
         end else begin
            exp = 4'b0000; tag = "R10";
         end
         check(tag, exp);
         if (k == abort_k) begin
            cs_n = 1'b1;
            @(negedge clk);
            check("R12", 4'b0000);
            @(negedge clk);
            check("R12", 4'b0000);
            return;
         end
      end
      cs_n = 1'b1;
      @(negedge clk);
      check("R12", 4'b0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R13: reset dominates a low chip select
      cs_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R13", 4'b0000);
      cs_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13", 4'b0000);

      for (int kd = 0; kd < 4; kd++)
         for (int cd = 0; cd < 16; cd++)
            for (int f = 0; f < 2; f++)
               for (int b = 0; b < 2; b++)
                  for (int p = 0; p < 2; p++)
                     run_txn(2'(kd), 4'(cd), f[0], b[0], p[0], -1);

      // R12: aborts in the address phase, just before the data pulse, zero-latency write
      run_txn(2'b00, 4'd2, 1'b0, 1'b1, 1'b1, 1);
      run_txn(2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 4);
      run_txn(2'b01, 4'd5, 1'b1, 1'b0, 1'b0, 19);
      run_txn(2'b11, 4'd1, 1'b0, 1'b0, 1'b0, 2);
      run_txn(2'b10, 4'd3, 1'b0, 1'b0, 1'b0, -1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule